// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an eight-pin general-purpose I/O port driven from a small register bus. Software sets the direction of each pin individually and loads the values that output pins drive. It can also read back the logic levels present on the pins. Each pin exposes an output-enable, an output value and an input value, which connect to a tri-state pad cell outside the block.

The direction register is write-only. It shares an address with the pin-input view, so a read at that address returns the synchronized pin levels rather than the stored direction bits. The output data register can be read and written at its own address at any time, whatever the direction settings.

A separate enable input hands the six upper pins to an attached peripheral function. While the enable is high, the peripheral supplies both the output-enable and the output value of those pins. The two lowest pins stay under register control at all times. The pad-facing outputs and the read data are registered.

Top module: `gpio_port`

## Requirements
- R1: A synchronous active-high reset clears the direction and output data registers, and the next clock edge after reset drives `pad_oe`, `pad_out` and `bus_rdata` to 0.
- R2: A write with `bus_we`=1 at address 0 loads `bus_wdata` into the direction register at the clock edge. For a pin under register control, `pad_oe` shows that bit one clock edge later.
- R3: A direction bit of 1 makes the pin an output (`pad_oe`=1). A direction bit of 0 makes it an input (`pad_oe`=0).
- R4: A read at address 0 returns the synchronized pin levels and never the direction register. `bus_rdata` is registered and reflects `bus_addr` one clock edge after it is presented.
- R5: Address 1 is the output data register for both writes and reads. It accepts writes and returns its contents whatever the direction bits are.
- R6: For a pin under register control, `pad_out` equals the matching output data bit one clock edge after the register changes.
- R7: While `periph_en`=1, pins 7..2 take `pad_oe` from `periph_oe` and `pad_out` from `periph_out` (bit 0 of those buses maps to pin 2), one clock edge later, and their direction and output data bits have no effect.
- R8: Pins 1 and 0 always follow the direction and output data registers, whatever the value of `periph_en`.
- R9: A change on `pad_in` reaches `bus_rdata` at address 0 on the third rising clock edge after it is applied: two synchronizer stages plus the read register. It is not visible earlier.
- R10: When `periph_en` returns to 0, pins 7..2 again follow the registers one clock edge later.
- R11: While `bus_we`=0, neither register changes, whatever `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 = direction (write) / pins (read), 1 = output data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| periph_en | input | 1 | Hands pins 7..2 to the peripheral |
| periph_oe | input | 6 | Peripheral output-enables for pins 7..2 |
| periph_out | input | 6 | Peripheral output values for pins 7..2 |
| pad_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin output-enable to the pads |
| pad_out | output | 8 | Per-pin driven value to the pads |

## Verification
On every cycle, the embedded assertions check the register write and hold rules, the two-edge synchronizer delay, the read data against the synchronized pins, and the per-pin source selection of the pad outputs, both overridden and register-controlled. Some behaviour is visible only at the ports through a sequence of operations, so the directed scenarios cover it. This includes that the aliased read never leaks the direction bits, that direction bits written during an override take effect once it is released, and the exact edge on which a pin change first shows up on the bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_DIR = 0;  // write: direction, read: pin levels
  localparam int ADDR_ODR = 1;  // output data, read/write
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    a_r9_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  odr_q,
  output logic [WIDTH-1:0]  rdata
);
  import gpio_pkg::*;
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_ODR = ADDR_W'(ADDR_ODR);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      odr_q <= '0;
    end else if (we) begin
      if (addr == A_DIR) dir_q <= wdata;
      if (addr == A_ODR) odr_q <= wdata;
    end
  end

  // direction bits are never visible on the read path
  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (addr == A_DIR) rdata <= pin_sync;
    else if (addr == A_ODR) rdata <= odr_q;
    else                    rdata <= '0;
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_DIR) |=> (dir_q == $past(wdata)));
  a_r5_odr_load: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_ODR) |=> (odr_q == $past(wdata)));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(dir_q) && $stable(odr_q)));
  a_r4_pin_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr) == A_DIR) |-> (rdata == $past(pin_sync)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH   = 8,
  parameter int OVR_LSB = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIDTH-1:0]         dir_q,
  input  logic [WIDTH-1:0]         odr_q,
  input  logic                     periph_en,
  input  logic [WIDTH-OVR_LSB-1:0] periph_oe,
  input  logic [WIDTH-OVR_LSB-1:0] periph_out,
  output logic [WIDTH-1:0]         pad_oe,
  output logic [WIDTH-1:0]         pad_out
);
  logic [WIDTH-1:0] oe_d, out_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= OVR_LSB) begin : g_ovr
      assign oe_d[i]  = periph_en ? periph_oe[i-OVR_LSB]  : dir_q[i];
      assign out_d[i] = periph_en ? periph_out[i-OVR_LSB] : odr_q[i];
    end else begin : g_fixed
      assign oe_d[i]  = dir_q[i];
      assign out_d[i] = odr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_d;
      pad_out <= out_d;
    end
  end

  a_r7_periph_drives: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(periph_en)) |->
      (pad_oe[WIDTH-1:OVR_LSB] == $past(periph_oe) &&
       pad_out[WIDTH-1:OVR_LSB] == $past(periph_out)));
  a_r10_regs_drive: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(periph_en)) |->
      (pad_oe[WIDTH-1:OVR_LSB] == $past(dir_q[WIDTH-1:OVR_LSB]) &&
       pad_out[WIDTH-1:OVR_LSB] == $past(odr_q[WIDTH-1:OVR_LSB])));
  if (OVR_LSB > 0) begin : g_low_chk
    a_r8_low_pins: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
        (pad_oe[OVR_LSB-1:0] == $past(dir_q[OVR_LSB-1:0]) &&
         pad_out[OVR_LSB-1:0] == $past(odr_q[OVR_LSB-1:0])));
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int OVR_LSB     = 2,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2,
  localparam int OVR_W      = WIDTH - OVR_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              periph_en,
  input  logic [OVR_W-1:0]  periph_oe,
  input  logic [OVR_W-1:0]  periph_out,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  logic [WIDTH-1:0] pin_sync, dir_q, odr_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pin_sync(pin_sync), .dir_q(dir_q), .odr_q(odr_q), .rdata(bus_rdata)
  );

  gpio_pad_mux #(.WIDTH(WIDTH), .OVR_LSB(OVR_LSB)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .odr_q(odr_q),
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [0:0] bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       periph_en = 1'b0;
  logic [5:0] periph_oe = '0;
  logic [5:0] periph_out = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_en(periph_en),
    .periph_oe(periph_oe), .periph_out(periph_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, register updates at the next posedge, return at negedge
  task automatic bus_write(logic [0:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [0:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    bus_read(1'b1, r);
    check("R1 odr after reset", r, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    bus_write(1'b0, 8'hA5);
    @(negedge clk);
    check("R2 R3 pad_oe follows direction", pad_oe, 8'hA5);
    pad_in = 8'h3C;
    bus_read(1'b0, r);
    repeat (2) @(negedge clk);
    r = bus_rdata;
    check("R4 addr0 reads pins, not direction", r, 8'h3C);
  endtask

  task automatic t_output_data();
    logic [7:0] r;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h5A);
    @(negedge clk);
    check("R6 pad_out from odr", pad_out, 8'h5A);
    check("R3 all inputs", pad_oe, 8'h00);
    bus_read(1'b1, r);
    check("R5 odr readback with dir=0", r, 8'h5A);
    bus_write(1'b0, 8'hFF);
    bus_write(1'b1, 8'hC3);
    bus_read(1'b1, r);
    check("R5 odr readback with dir=FF", r, 8'hC3);
  endtask

  task automatic t_write_gate();
    logic [7:0] r;
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = 8'h00; bus_we = 1'b0;
    @(negedge clk);
    bus_addr = 1'b1; bus_wdata = 8'h11;
    repeat (2) @(negedge clk);
    check("R11 dir unchanged with we=0", pad_oe, 8'hFF);
    check("R11 odr unchanged on pads", pad_out, 8'hC3);
    bus_read(1'b1, r);
    check("R11 odr unchanged readback", r, 8'hC3);
  endtask

  task automatic t_override();
    bus_write(1'b0, 8'h0F);
    bus_write(1'b1, 8'hF0);
    @(negedge clk);
    periph_oe = 6'b101010; periph_out = 6'b010011; periph_en = 1'b1;
    @(negedge clk);
    check("R7 R8 pad_oe under override", pad_oe, 8'hAB);
    check("R7 R8 pad_out under override", pad_out, 8'h4C);
    bus_write(1'b0, 8'h00);
    @(negedge clk);
    check("R7 upper dir ignored, R8 lower follows", pad_oe, 8'hA8);
    bus_write(1'b0, 8'h3C);
    bus_write(1'b1, 8'h03);
    @(negedge clk);
    check("R8 lower pins under override", pad_oe & 8'h03, 8'h00);
    check("R8 lower out under override", pad_out, 8'h4F);
    periph_en = 1'b0;
    @(negedge clk);
    check("R10 release pad_oe", pad_oe, 8'h3C);
    check("R10 release pad_out", pad_out, 8'h03);
  endtask

  task automatic t_latency();
    @(negedge clk);
    bus_addr = 1'b0; pad_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R9 baseline", bus_rdata, 8'h00);
    pad_in = 8'h81;
    repeat (2) @(negedge clk);
    check("R9 not visible after two edges", bus_rdata, 8'h00);
    @(negedge clk);
    check("R9 visible on third edge", bus_rdata, 8'h81);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direction();
    t_output_data();
    t_write_gate();
    t_override();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule